// File: doc/BRIEF.md
# Mode-Banked Shadow Register File

This block is a 64-bit integer register file with two combinational read ports and one clocked write port. It sits behind a privileged-mode flag. While the flag is clear, every register number selects the ordinary architectural array. While the flag is set, a fixed, non-contiguous group of register numbers is steered to a separate eight-entry shadow bank. The privileged code can then use those registers as scratch space without disturbing the values that unprivileged code left there.

Register numbers are five bits wide. Numbers 0 to 30 are real storage, and number 31 is a hardwired zero. Reads and writes apply the same mode-dependent mapping. A read that names the location being written in the same cycle returns the incoming data. The mapping is applied before that comparison, so the bypass only fires when both accesses reach the same physical entry. Saving or restoring the shadow bank on a mode change is the job of the surrounding core.

Top module: `banked_regfile`

## Requirements
- R1: A write with `wr_en` high to register 0..30 is stored at the rising clock edge. A later read of the same register number, under the same mode, returns that 64-bit value until the location is written again.
- R2: With `priv_mode` low, every register number 0..30 reaches the main array, including 8..14 and 25.
- R3: With `priv_mode` high, register numbers 8, 9, 10, 11, 12, 13 and 14 reach shadow entries 0 to 6 in that order. A privileged write to one of them leaves the main-array value seen in unprivileged mode unchanged.
- R4: With `priv_mode` high, register number 25 reaches shadow entry 7. A privileged write to 25 does not change main register 25.
- R5: With `priv_mode` high, all other numbers (0..7, 15..24, 26..30) reach the main array. A value written in either mode is visible in the other mode.
- R6: Register number 31 always reads as zero on both ports, and a write to it changes no storage.
- R7: When `wr_en` is high and a read port names a location that maps to the same physical entry as `wr_addr` under the current mode, that port returns `wr_data` in the same cycle. No bypass happens for register 31.
- R8: While `rst_n` is low, every main and shadow entry is cleared to zero. After reset, every read returns zero in both modes until it is written.
- R9: The two read ports are independent. Each port returns the value for its own address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears both arrays |
| priv_mode | input | 1 | High selects the shadow mapping for both reads and the write |
| rd_addr_a | input | 5 | Register number for read port A |
| rd_data_a | output | 64 | Combinational read data for port A |
| rd_addr_b | input | 5 | Register number for read port B |
| rd_data_b | output | 64 | Combinational read data for port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Register number to write |
| wr_data | input | 64 | Data to write |

## Verification
A decode fault in the banking logic shows up as a value leak between modes. A privileged write to register 9 or 25 would reappear in unprivileged reads, or a shared register written in one mode would read stale in the other. This is visible on the first read of that number after the write, one clock later. A fault in the bypass comparison shows up in the same cycle as the write, as stale data on a read port. A stuck or uncleared storage entry shows up as a nonzero value on the first read after reset. The bench therefore reads every register in both modes right after each reset, and it checks same-cycle reads on every random cycle.

// File: rtl/srf_pkg.sv
`timescale 1ns/1ps
package srf_pkg;
   // Which physical store a register number reaches after mode mapping.
   typedef enum logic [1:0] {
      BANK_MAIN   = 2'd0,
      BANK_SHADOW = 2'd1,
      BANK_ZERO   = 2'd2
   } bank_t;
endpackage

// File: rtl/srf_map_decode.sv
`timescale 1ns/1ps
module srf_map_decode
   import srf_pkg::*;
#(
   parameter int ADDR_W       = 5,
   parameter int NUM_REGS     = 31,
   parameter int SHADOW_BASE  = 8,
   parameter int SHADOW_RUN   = 7,
   parameter int SHADOW_EXTRA = 25,
   parameter int SH_W         = 3
) (
   input  logic              priv,
   input  logic [ADDR_W-1:0] addr,
   output bank_t             bank,
   output logic [ADDR_W-1:0] main_idx,
   output logic [SH_W-1:0]   sh_idx
);
   localparam logic [ADDR_W-1:0] ZERO_A  = ADDR_W'(NUM_REGS);
   localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(SHADOW_BASE);
   localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(SHADOW_BASE + SHADOW_RUN - 1);
   localparam logic [ADDR_W-1:0] EXTRA_A = ADDR_W'(SHADOW_EXTRA);
   localparam logic [SH_W-1:0]   EXTRA_S = SH_W'(SHADOW_RUN);

   always_comb begin
      main_idx = addr;
      sh_idx   = '0;
      if (addr == ZERO_A) begin
         bank = BANK_ZERO;
      end else if (priv && (addr >= BASE_A) && (addr <= LAST_A)) begin
         bank   = BANK_SHADOW;
         sh_idx = SH_W'(addr - BASE_A);
      end else if (priv && (addr == EXTRA_A)) begin
         bank   = BANK_SHADOW;
         sh_idx = EXTRA_S;
      end else begin
         bank = BANK_MAIN;
      end
   end
endmodule

// File: rtl/srf_storage.sv
`timescale 1ns/1ps
module srf_storage #(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 31,
   parameter int NRD    = 2,
   parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic [DATA_W-1:0]           wr_data,
   input  logic [NRD-1:0][IDX_W-1:0]   rd_idx,
   output logic [NRD-1:0][DATA_W-1:0]  rd_q
);
   localparam logic [IDX_W:0] DEPTH_L = (IDX_W+1)'(DEPTH);

   if (DEPTH > (1 << IDX_W)) begin : g_bad_idx
      $error("srf_storage: IDX_W too narrow for DEPTH");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we && ({1'b0, wr_idx} < DEPTH_L)) begin
         mem[wr_idx] <= wr_data;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rd_q[p] = ({1'b0, rd_idx[p]} < DEPTH_L) ? mem[rd_idx[p]] : '0;
   end
endmodule

// File: rtl/srf_read_port.sv
`timescale 1ns/1ps
module srf_read_port
   import srf_pkg::*;
#(
   parameter int DATA_W      = 64,
   parameter int ADDR_W      = 5,
   parameter int SH_W        = 3,
   parameter bit WRITE_FIRST = 1'b1
) (
   input  bank_t             rd_bank,
   input  logic [ADDR_W-1:0] rd_main_idx,
   input  logic [SH_W-1:0]   rd_sh_idx,
   input  logic [DATA_W-1:0] main_q,
   input  logic [DATA_W-1:0] sh_q,
   input  logic              wr_en,
   input  bank_t             wr_bank,
   input  logic [ADDR_W-1:0] wr_main_idx,
   input  logic [SH_W-1:0]   wr_sh_idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] stored;
   logic              hit;

   always_comb begin
      unique case (rd_bank)
         BANK_MAIN:   stored = main_q;
         BANK_SHADOW: stored = sh_q;
         default:     stored = '0;
      endcase
   end

   always_comb begin
      hit = 1'b0;
      if (wr_en && (wr_bank == rd_bank)) begin
         if (rd_bank == BANK_MAIN)        hit = (wr_main_idx == rd_main_idx);
         else if (rd_bank == BANK_SHADOW) hit = (wr_sh_idx == rd_sh_idx);
      end
   end

   if (WRITE_FIRST) begin : g_bypass
      assign rd_data = hit ? wr_data : stored;
   end else begin : g_no_bypass
      logic unused_hit;
      assign unused_hit = hit;
      assign rd_data = stored;
   end
endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile
   import srf_pkg::*;
#(
   parameter int DATA_W       = 64,
   parameter int NUM_REGS     = 31,
   parameter int SHADOW_BASE  = 8,
   parameter int SHADOW_RUN   = 7,
   parameter int SHADOW_EXTRA = 25,
   parameter bit WRITE_FIRST  = 1'b1,
   parameter int ADDR_W       = $clog2(NUM_REGS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              priv_mode,
   input  logic [ADDR_W-1:0] rd_addr_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [ADDR_W-1:0] rd_addr_b,
   output logic [DATA_W-1:0] rd_data_b,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int NRD      = 2;
   localparam int SH_DEPTH = SHADOW_RUN + 1;
   localparam int SH_W     = $clog2(SH_DEPTH);

   if (DATA_W < 1) begin : g_bad_w
      $error("banked_regfile: DATA_W must be positive");
   end
   if ((NUM_REGS + 1) != (1 << ADDR_W)) begin : g_bad_n
      $error("banked_regfile: zero register must be the top register number");
   end
   if (SHADOW_RUN < 1 || SHADOW_BASE + SHADOW_RUN > NUM_REGS) begin : g_bad_run
      $error("banked_regfile: shadow run outside register range");
   end
   if (SHADOW_EXTRA >= NUM_REGS ||
       (SHADOW_EXTRA >= SHADOW_BASE && SHADOW_EXTRA < SHADOW_BASE + SHADOW_RUN)) begin : g_bad_x
      $error("banked_regfile: extra shadowed register overlaps run or zero");
   end

   logic [NRD-1:0][ADDR_W-1:0] rd_addr;
   logic [NRD-1:0][DATA_W-1:0] rd_data;
   assign rd_addr[0] = rd_addr_a;
   assign rd_addr[1] = rd_addr_b;
   assign rd_data_a  = rd_data[0];
   assign rd_data_b  = rd_data[1];

   bank_t                      rd_bank  [NRD];
   logic [NRD-1:0][ADDR_W-1:0] rd_midx;
   logic [NRD-1:0][SH_W-1:0]   rd_sidx;
   logic [NRD-1:0][DATA_W-1:0] main_q;
   logic [NRD-1:0][DATA_W-1:0] sh_q;

   bank_t             wr_bank;
   logic [ADDR_W-1:0] wr_midx;
   logic [SH_W-1:0]   wr_sidx;

   srf_map_decode #(
      .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .SHADOW_BASE(SHADOW_BASE),
      .SHADOW_RUN(SHADOW_RUN), .SHADOW_EXTRA(SHADOW_EXTRA), .SH_W(SH_W)
   ) u_wr_dec (
      .priv(priv_mode), .addr(wr_addr),
      .bank(wr_bank), .main_idx(wr_midx), .sh_idx(wr_sidx)
   );

   for (genvar p = 0; p < NRD; p++) begin : g_port
      srf_map_decode #(
         .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .SHADOW_BASE(SHADOW_BASE),
         .SHADOW_RUN(SHADOW_RUN), .SHADOW_EXTRA(SHADOW_EXTRA), .SH_W(SH_W)
      ) u_rd_dec (
         .priv(priv_mode), .addr(rd_addr[p]),
         .bank(rd_bank[p]), .main_idx(rd_midx[p]), .sh_idx(rd_sidx[p])
      );

      srf_read_port #(
         .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SH_W(SH_W), .WRITE_FIRST(WRITE_FIRST)
      ) u_port (
         .rd_bank(rd_bank[p]), .rd_main_idx(rd_midx[p]), .rd_sh_idx(rd_sidx[p]),
         .main_q(main_q[p]), .sh_q(sh_q[p]),
         .wr_en(wr_en), .wr_bank(wr_bank), .wr_main_idx(wr_midx),
         .wr_sh_idx(wr_sidx), .wr_data(wr_data),
         .rd_data(rd_data[p])
      );
   end

   srf_storage #(
      .DATA_W(DATA_W), .DEPTH(NUM_REGS), .NRD(NRD), .IDX_W(ADDR_W)
   ) u_main (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && (wr_bank == BANK_MAIN)), .wr_idx(wr_midx), .wr_data(wr_data),
      .rd_idx(rd_midx), .rd_q(main_q)
   );

   srf_storage #(
      .DATA_W(DATA_W), .DEPTH(SH_DEPTH), .NRD(NRD), .IDX_W(SH_W)
   ) u_shadow (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && (wr_bank == BANK_SHADOW)), .wr_idx(wr_sidx), .wr_data(wr_data),
      .rd_idx(rd_sidx), .rd_q(sh_q)
   );
endmodule

// File: rtl/srf_checker.sv
`timescale 1ns/1ps
module srf_checker #(
   parameter int DATA_W      = 64,
   parameter int ADDR_W      = 5,
   parameter int NUM_REGS    = 31,
   parameter int SHADOW_BASE = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              priv_mode,
   input logic [ADDR_W-1:0] rd_addr_a,
   input logic [DATA_W-1:0] rd_data_a,
   input logic [ADDR_W-1:0] rd_addr_b,
   input logic [DATA_W-1:0] rd_data_b,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data
);
   localparam logic [ADDR_W-1:0] ZERO_A = ADDR_W'(NUM_REGS);
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(SHADOW_BASE);

   assert_zero_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr_a == ZERO_A) |-> (rd_data_a == '0));

   assert_zero_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr_b == ZERO_A) |-> (rd_data_b == '0));

   assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr != ZERO_A) && (wr_addr == rd_addr_a)) |-> (rd_data_a == wr_data));

   assert_persist_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && ($past(wr_addr) != ZERO_A) && (rd_addr_a == $past(wr_addr)) &&
       (priv_mode == $past(priv_mode)) && !(wr_en && (wr_addr == rd_addr_a)))
      |-> (rd_data_a == $past(wr_data)));

   assert_shared_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && $past(priv_mode) && ($past(wr_addr) < BASE_A) && !priv_mode &&
       (rd_addr_b == $past(wr_addr)) && !(wr_en && (wr_addr == rd_addr_b)))
      |-> (rd_data_b == $past(wr_data)));
endmodule

bind banked_regfile srf_checker #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .SHADOW_BASE(SHADOW_BASE)
) u_srf_checker (
   .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode),
   .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
   .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        priv_mode = 1'b0;
   logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
   logic [63:0] rd_data_a, rd_data_b, wr_data = '0;
   logic        wr_en = 1'b0;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [63:0] mm [31];
   logic [63:0] sh [8];

   always #2.5 clk = ~clk;

   banked_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode),
      .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
      .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   // -1 zero register, 0..30 main, 100..107 shadow
   function automatic int code_of(logic [4:0] a, logic p);
      if (a == 5'd31) return -1;
      if (p && a >= 5'd8 && a <= 5'd14) return 100 + int'(a) - 8;
      if (p && a == 5'd25) return 107;
      return int'(a);
   endfunction

   function automatic logic [63:0] peek(int c);
      if (c < 0) return '0;
      if (c >= 100) return sh[c-100];
      return mm[c];
   endfunction

   function automatic logic [63:0] expect_rd(logic [4:0] ra);
      int c = code_of(ra, priv_mode);
      if (wr_en && c >= 0 && c == code_of(wr_addr, priv_mode)) return wr_data;
      return peek(c);
   endfunction

   function automatic string tag_of(logic [4:0] a, logic p);
      int c = code_of(a, p);
      if (c < 0) return "R6";
      if (c == 107) return "R4";
      if (c >= 100) return "R3";
      return p ? "R5" : "R2";
   endfunction

   task automatic chk(string req, string port, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s port %s: actual %h expected %h", req, port, act, exp);
      end
   endtask

   task automatic clear_model();
      for (int i = 0; i < 31; i++) mm[i] = '0;
      for (int i = 0; i < 8; i++) sh[i] = '0;
   endtask

   // Drive one cycle, check both ports before the edge, then commit the model.
   task automatic step(logic we, logic [4:0] wa, logic [63:0] wd, logic pm,
                       logic [4:0] ra, logic [4:0] rb, string req);
      int c;
      @(posedge clk);
      #1;
      wr_en = we; wr_addr = wa; wr_data = wd; priv_mode = pm;
      rd_addr_a = ra; rd_addr_b = rb;
      @(negedge clk);
      chk(req, "A", rd_data_a, expect_rd(ra));
      chk(req, "B", rd_data_b, expect_rd(rb));
      c = code_of(wa, pm);
      if (we && c >= 0) begin
         if (c >= 100) sh[c-100] = wd;
         else mm[c] = wd;
      end
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      wr_en = 1'b0; rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      clear_model();
   endtask

   task automatic sweep_zero(string req);
      for (int a = 0; a < 32; a++) begin
         step(1'b0, 5'd0, '0, 1'b0, 5'(a), 5'(31 - a), req);
         chk(req, "A0", rd_data_a, 64'd0);
         step(1'b0, 5'd0, '0, 1'b1, 5'(a), 5'(31 - a), req);
         chk(req, "A1", rd_data_a, 64'd0);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      clear_model();
      do_reset();
      sweep_zero("R8");

      // R1 / R2: fill main array in user mode, read back on both ports (R9)
      for (int a = 0; a < 31; a++)
         step(1'b1, 5'(a), 64'hA5A5_0000_0000_0000 | 64'(a), 1'b0, 5'(a), 5'(30 - a), "R7");
      for (int a = 0; a < 31; a++)
         step(1'b0, 5'd0, '0, 1'b0, 5'(a), 5'((a + 5) % 31), "R1");

      // R3: privileged writes to 8..14 hit shadow, user view unchanged
      for (int a = 8; a <= 14; a++)
         step(1'b1, 5'(a), 64'h5AD0_0000_0000_0000 | 64'(a), 1'b1, 5'(a), 5'd0, "R3");
      for (int a = 8; a <= 14; a++) begin
         step(1'b0, 5'd0, '0, 1'b0, 5'(a), 5'(a), "R3");
         chk("R3", "user", rd_data_a, 64'hA5A5_0000_0000_0000 | 64'(a));
         step(1'b0, 5'd0, '0, 1'b1, 5'(a), 5'(a), "R3");
         chk("R3", "priv", rd_data_a, 64'h5AD0_0000_0000_0000 | 64'(a));
      end

      // R4: register 25 in privileged mode
      step(1'b1, 5'd25, 64'hDEAD_BEEF_2525_2525, 1'b1, 5'd0, 5'd25, "R4");
      step(1'b0, 5'd0, '0, 1'b0, 5'd25, 5'd24, "R4");
      chk("R4", "user", rd_data_a, 64'hA5A5_0000_0000_0019);
      step(1'b0, 5'd0, '0, 1'b1, 5'd25, 5'd26, "R4");
      chk("R4", "priv", rd_data_a, 64'hDEAD_BEEF_2525_2525);

      // R5: unbanked register written in privileged mode is shared
      step(1'b1, 5'd15, 64'h0123_4567_89AB_CDEF, 1'b1, 5'd7, 5'd15, "R5");
      step(1'b0, 5'd0, '0, 1'b0, 5'd15, 5'd7, "R5");
      chk("R5", "user", rd_data_a, 64'h0123_4567_89AB_CDEF);

      // R6: writes to 31 are dropped in both modes
      step(1'b1, 5'd31, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 5'd31, 5'd31, "R6");
      step(1'b1, 5'd31, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 5'd31, 5'd0, "R6");
      chk("R6", "A", rd_data_a, 64'd0);

      // R7: same-cycle bypass follows mapping
      step(1'b1, 5'd12, 64'hB0B0_1212_0000_0001, 1'b1, 5'd12, 5'd11, "R7");
      chk("R7", "priv", rd_data_a, 64'hB0B0_1212_0000_0001);
      step(1'b1, 5'd12, 64'hB0B0_1212_0000_0002, 1'b0, 5'd13, 5'd12, "R7");
      chk("R7", "user", rd_data_b, 64'hB0B0_1212_0000_0002);

      // R8: reset in the middle clears both arrays
      do_reset();
      sweep_zero("R8");

      // Random traffic, both modes
      for (int i = 0; i < 4000; i++) begin
         logic [4:0] ra, rb, wa;
         logic       pm, we;
         ra = 5'($urandom_range(0, 31));
         rb = 5'($urandom_range(0, 31));
         wa = ($urandom_range(0, 3) == 0) ? ra : 5'($urandom_range(0, 31));
         pm = 1'($urandom_range(0, 1));
         we = ($urandom_range(0, 9) < 7);
         step(we, wa, {$urandom, $urandom}, pm, ra, rb, tag_of(ra, pm));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule